// File: doc/BRIEF.md
# Key-Sequenced Watchdog Timer

This block is a watchdog for a system that must prove it is alive. A counter of configurable width counts upward on a slow reference tick enable. Software loads the negative of the wanted tick budget, so the counter reaches zero after that many ticks. When it steps past all-ones, it reloads from a load register, sets an overflow flag, and raises a reset request for one clock. The request is a plain output that a separate reset generator consumes.

Arming and disarming take a two-word key sequence written to a key register. This guards against a runaway program that stops the watchdog with a single stray store. Key writes are posted. Each one takes effect a fixed number of reference ticks after the bus write, and a pending bit can be polled meanwhile. Further registers provide a soft reset with a completion flag, a maskable interrupt, a counter prescaler, a trigger that reloads the counter, and two stored configuration bits.

Top module: `wdt_top`

## Requirements
- R1: After `rst_n` is low at a clock edge, every register reads zero, except status 0x14 bit 0 (reset done), which reads 1. `irq` and `rst_req` are 0 and the counter is stopped.
- R2: While the counter runs with the prescaler off, it increases by one on each clock with `tick_en` high. A bus write to 0x28 replaces the counter value. Any write to 0x30 copies load register 0x2C into the counter.
- R3: A counting step from all-ones loads the counter from 0x2C and sets bit 0 of 0x18. In the same step `rst_req` goes high for exactly one clock.
- R4: Applying key word 0xBBBB followed by 0x4444 through register 0x48 starts the counter.
- R5: Applying 0xAAAA followed by 0x5555 stops the counter. A stopped counter keeps its value.
- R6: If the key word after a first word is not that word's partner, the sequence is abandoned and the run state stays as it was. A word that is not a first word, received when no sequence is open, has no effect.
- R7: A key write takes effect on the fourth `tick_en` after the write. Bit 4 of 0x34 reads 1 from the clock after the write through that fourth tick. A key write made while one is pending is dropped, and 0x48 reads back the last accepted word in bits 15:0.
- R8: `irq` is high exactly when 0x18 bit 0 and 0x1C bit 0 are both set. Writing 1 to 0x18 bit 0 clears the flag, but an overflow in the same clock keeps it set.
- R9: Writing 1 to bit 1 of 0x10 clears all state. For the next 4 clocks, 0x14 bit 0 reads 0, 0x10 bit 1 reads 1, and bus writes are ignored.
- R10: Bit 5 of 0x24 enables the prescaler and bits 4:2 hold a field p. With the prescaler on, the counter advances once per 2^(p+1) ticks. A write to 0x24 restarts the prescale phase.
- R11: Bit 3 of 0x10 and bit 0 of 0x20 read back the last value written to them. Neither changes how the counter advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Reference-clock enable, one clock wide per tick |
| bus_sel | input | 1 | Register access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked overflow interrupt |
| rst_req | output | 1 | One-clock reset request on overflow |

## Verification
The hardest case to reach is a key write that arrives while an earlier one is still posted, combined with sparse reference ticks. Here a wrong ordering of the drop logic and the tick countdown would stay hidden. The bench sets ticks to every third clock, posts a start word, and writes a stop word inside the pending window. It then confirms that the dropped word changed neither the read-back key nor the run state. A behavioural model tracks every register on every clock, so prescaler phases and overflow reloads are also compared during long unattended runs.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the key-sequenced watchdog.
// Assumes a byte-addressed register window of at least 8 address bits.
package wdt_pkg;

    localparam logic [7:0] A_CFG   = 8'h10;
    localparam logic [7:0] A_STAT  = 8'h14;
    localparam logic [7:0] A_ISR   = 8'h18;
    localparam logic [7:0] A_IER   = 8'h1C;
    localparam logic [7:0] A_WAKE  = 8'h20;
    localparam logic [7:0] A_CTRL  = 8'h24;
    localparam logic [7:0] A_CNT   = 8'h28;
    localparam logic [7:0] A_LOAD  = 8'h2C;
    localparam logic [7:0] A_TRIG  = 8'h30;
    localparam logic [7:0] A_PEND  = 8'h34;
    localparam logic [7:0] A_KEY   = 8'h48;

    localparam int KEY_W = 16;
    localparam logic [KEY_W-1:0] KEY_ARM_A    = 16'hBBBB;
    localparam logic [KEY_W-1:0] KEY_ARM_B    = 16'h4444;
    localparam logic [KEY_W-1:0] KEY_DISARM_A = 16'hAAAA;
    localparam logic [KEY_W-1:0] KEY_DISARM_B = 16'h5555;

    localparam int PTV_W = 3;

    typedef enum logic [1:0] {
        KS_IDLE   = 2'd0,
        KS_ARM    = 2'd1,
        KS_DISARM = 2'd2
    } key_stage_t;

    typedef struct packed {
        logic             en;
        logic [PTV_W-1:0] ptv;
    } prescale_t;

endpackage

// File: rtl/wdt_keyseq.sv
// Posted key register and two-word arm/disarm sequencer.
// A bus key write is latched, held pending for POST_TICKS reference ticks,
// then applied to the sequence state. Writes while pending are dropped.
// Assumes POST_TICKS >= 2 and that srst is a one-clock strobe.
module wdt_keyseq
    import wdt_pkg::*;
#(
    parameter int POST_TICKS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             tick_en,
    input  logic             key_wr,
    input  logic [KEY_W-1:0] key_data,
    output logic             run,
    output logic             pend,
    output logic [KEY_W-1:0] key_last
);

    localparam int PC_W = $clog2(POST_TICKS);
    localparam logic [PC_W-1:0] PC_LAST = PC_W'(POST_TICKS - 1);

    logic [PC_W-1:0] post_cnt;
    key_stage_t      stage;
    key_stage_t      stage_nxt;
    logic            run_nxt;
    logic            apply_now;

    // Purpose: the posted word is applied on the final countdown tick.
    assign apply_now = pend && tick_en && (post_cnt == PC_LAST);

    // Purpose: next sequence stage and run state when the posted word lands.
    always_comb begin
        stage_nxt = KS_IDLE;
        run_nxt   = run;
        unique case (stage)
            KS_ARM: begin
                if (key_last == KEY_ARM_B) run_nxt = 1'b1;
            end
            KS_DISARM: begin
                if (key_last == KEY_DISARM_B) run_nxt = 1'b0;
            end
            default: begin
                if (key_last == KEY_ARM_A)         stage_nxt = KS_ARM;
                else if (key_last == KEY_DISARM_A) stage_nxt = KS_DISARM;
            end
        endcase
    end

    // Purpose: post the key word and count reference ticks until it applies.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            pend     <= 1'b0;
            post_cnt <= '0;
            key_last <= '0;
        end else if (key_wr && !pend) begin
            pend     <= 1'b1;
            post_cnt <= '0;
            key_last <= key_data;
        end else if (pend && tick_en) begin
            if (post_cnt == PC_LAST) pend <= 1'b0;
            else                     post_cnt <= post_cnt + 1'b1;
        end
    end

    // Purpose: hold sequence stage and run state, updated only on apply.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            stage <= KS_IDLE;
            run   <= 1'b0;
        end else if (apply_now) begin
            stage <= stage_nxt;
            run   <= run_nxt;
        end
    end

endmodule

// File: rtl/wdt_count.sv
// Prescaler, up-counter with reload on wrap, and reset request pulse.
// Assumes CNT_W <= DATA_W of the bus and that bus strobes are one clock wide.
module wdt_count
    import wdt_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             srst,
    input  logic             tick_en,
    input  logic             run,
    input  prescale_t        pre,
    input  logic             ctrl_wr,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic             trig,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt_val,
    output logic             ovf,
    output logic             rst_req
);

    localparam int PRE_W = 2 ** PTV_W;

    logic [PRE_W:0]   lim_full;
    logic [PRE_W-1:0] pre_lim;
    logic [PRE_W-1:0] pre_cnt;
    logic             step;
    logic             adv;
    logic             at_top;

    // Purpose: prescale limit 2^(p+1)-1, computed one bit wider than needed.
    assign lim_full = ((PRE_W+1)'(1) << ({1'b0, pre.ptv} + 4'd1)) - (PRE_W+1)'(1);
    assign pre_lim  = lim_full[PRE_W-1:0];

    assign step   = run && tick_en;
    assign adv    = step && (!pre.en || (pre_cnt == pre_lim));
    assign at_top = &cnt_val;
    assign ovf    = adv && at_top && !cnt_wr && !trig;

    // Purpose: prescale phase counter, restarted by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n || srst || ctrl_wr) begin
            pre_cnt <= '0;
        end else if (step && pre.en) begin
            pre_cnt <= (pre_cnt == pre_lim) ? '0 : pre_cnt + 1'b1;
        end
    end

    // Purpose: main counter; bus write beats trigger beats counting.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            cnt_val <= '0;
        end else if (cnt_wr) begin
            cnt_val <= cnt_wdata;
        end else if (trig) begin
            cnt_val <= load_val;
        end else if (adv) begin
            cnt_val <= at_top ? load_val : cnt_val + 1'b1;
        end
    end

    // Purpose: one-clock reset request in step with the overflow flag.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) rst_req <= 1'b0;
        else                rst_req <= ovf;
    end

endmodule

// File: rtl/wdt_regs.sv
// Register decode, soft reset sequencing, interrupt flag and read mux.
// Assumes a single-cycle bus: a write lands on the clock edge where sel and we
// are high; reads are combinational on bus_addr.
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int CNT_W     = 32,
    parameter int SR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              ovf,
    input  logic [CNT_W-1:0]  cnt_val,
    input  logic              pend,
    input  logic [KEY_W-1:0]  key_last,
    output logic              srst,
    output logic              key_wr,
    output logic              cnt_wr,
    output logic              trig,
    output logic              ctrl_wr,
    output logic [CNT_W-1:0]  load_val,
    output prescale_t         pre,
    output logic              isr_flag,
    output logic              irq,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int BW = $clog2(SR_CYCLES + 1);

    logic [BW-1:0] busy_cnt;
    logic          busy;
    logic          wr;
    logic          idle_bit;
    logic          ier_bit;
    logic          wake_bit;

    // Purpose: decode one-clock write strobes, gated off during soft reset.
    function automatic logic hit(input logic [7:0] a);
        return bus_addr == ADDR_W'(a);
    endfunction

    assign busy    = (busy_cnt != '0);
    assign wr      = bus_sel && bus_we && !busy;
    assign srst    = wr && hit(A_CFG) && bus_wdata[1];
    assign key_wr  = wr && hit(A_KEY);
    assign cnt_wr  = wr && hit(A_CNT);
    assign trig    = wr && hit(A_TRIG);
    assign ctrl_wr = wr && hit(A_CTRL);
    assign irq     = isr_flag && ier_bit;

    // Purpose: soft reset busy window after the reset strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_cnt <= '0;
        else if (srst)    busy_cnt <= BW'(SR_CYCLES);
        else if (busy)    busy_cnt <= busy_cnt - 1'b1;
    end

    // Purpose: plain configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            idle_bit <= 1'b0;
            ier_bit  <= 1'b0;
            wake_bit <= 1'b0;
            load_val <= '0;
            pre      <= '0;
        end else if (wr) begin
            if (hit(A_CFG))  idle_bit <= bus_wdata[3];
            if (hit(A_IER))  ier_bit  <= bus_wdata[0];
            if (hit(A_WAKE)) wake_bit <= bus_wdata[0];
            if (hit(A_LOAD)) load_val <= bus_wdata[CNT_W-1:0];
            if (ctrl_wr)     pre      <= '{en: bus_wdata[5], ptv: bus_wdata[4:2]};
        end
    end

    // Purpose: overflow flag, write-one-to-clear, set has priority.
    always_ff @(posedge clk) begin
        if (!rst_n || srst) begin
            isr_flag <= 1'b0;
        end else begin
            if (wr && hit(A_ISR) && bus_wdata[0]) isr_flag <= 1'b0;
            if (ovf)                              isr_flag <= 1'b1;
        end
    end

    // Purpose: read data mux.
    always_comb begin
        bus_rdata = '0;
        if (hit(A_CFG)) begin
            bus_rdata[3] = idle_bit;
            bus_rdata[1] = busy;
        end
        if (hit(A_STAT)) bus_rdata[0] = !busy;
        if (hit(A_ISR))  bus_rdata[0] = isr_flag;
        if (hit(A_IER))  bus_rdata[0] = ier_bit;
        if (hit(A_WAKE)) bus_rdata[0] = wake_bit;
        if (hit(A_CTRL)) begin
            bus_rdata[5]   = pre.en;
            bus_rdata[4:2] = pre.ptv;
        end
        if (hit(A_CNT))  bus_rdata[CNT_W-1:0] = cnt_val;
        if (hit(A_LOAD)) bus_rdata[CNT_W-1:0] = load_val;
        if (hit(A_PEND)) bus_rdata[4] = pend;
        if (hit(A_KEY))  bus_rdata[KEY_W-1:0] = key_last;
    end

endmodule

// File: rtl/wdt_top.sv
// Key-sequenced watchdog top: ties register block, key sequencer and counter.
// Assumes tick_en is already synchronous to clk.
module wdt_top
    import wdt_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 32,
    parameter int CNT_W      = 32,
    parameter int POST_TICKS = 4,
    parameter int SR_CYCLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq,
    output logic              rst_req
);

    logic             srst;
    logic             key_wr;
    logic             cnt_wr;
    logic             trig;
    logic             ctrl_wr;
    logic [CNT_W-1:0] load_val;
    logic [CNT_W-1:0] cnt_val;
    prescale_t        pre;
    logic             isr_flag;
    logic             ovf;
    logic             run;
    logic             pend;
    logic [KEY_W-1:0] key_last;

    wdt_regs #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .SR_CYCLES(SR_CYCLES)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ovf(ovf), .cnt_val(cnt_val),
        .pend(pend), .key_last(key_last), .srst(srst), .key_wr(key_wr),
        .cnt_wr(cnt_wr), .trig(trig), .ctrl_wr(ctrl_wr), .load_val(load_val),
        .pre(pre), .isr_flag(isr_flag), .irq(irq), .bus_rdata(bus_rdata)
    );

    wdt_keyseq #(.POST_TICKS(POST_TICKS)) u_keys (
        .clk(clk), .rst_n(rst_n), .srst(srst), .tick_en(tick_en),
        .key_wr(key_wr), .key_data(bus_wdata[KEY_W-1:0]),
        .run(run), .pend(pend), .key_last(key_last)
    );

    wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .srst(srst), .tick_en(tick_en), .run(run),
        .pre(pre), .ctrl_wr(ctrl_wr), .cnt_wr(cnt_wr),
        .cnt_wdata(bus_wdata[CNT_W-1:0]), .trig(trig), .load_val(load_val),
        .cnt_val(cnt_val), .ovf(ovf), .rst_req(rst_req)
    );

endmodule

// File: rtl/wdt_chk.sv
// Assertion checker for wdt_top, attached with bind below.
// Assumes it sees the top's internal run, pending and counter signals.
module wdt_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick_en,
    input logic             srst,
    input logic             run,
    input logic             pend,
    input logic             cnt_wr,
    input logic             trig,
    input logic             isr_flag,
    input logic             rst_req,
    input logic [CNT_W-1:0] cnt_val
);

    AST_REQ_ONE_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req); // R3
    AST_REQ_WITH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> isr_flag); // R3
    AST_ARM_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> $fell(pend)); // R4
    AST_DISARM_ON_APPLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(run) |-> ($fell(pend) || $past(srst))); // R5
    AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !cnt_wr && !trig && !srst) |=> $stable(cnt_val)); // R5
    AST_PEND_WAITS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (pend && !tick_en && !srst) |=> pend); // R7

endmodule

bind wdt_top wdt_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .srst(srst), .run(run),
    .pend(pend), .cnt_wr(cnt_wr), .trig(trig), .isr_flag(isr_flag),
    .rst_req(rst_req), .cnt_val(cnt_val)
);

// File: tb/tb_wdt_top.sv
module tb_wdt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    logic        rst_req;

    int errors = 0;
    int checks = 0;
    int tick_per = 0;
    bit done = 1'b0;

    wdt_top dut (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_sel(bus_sel),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
    );

    always #4 clk = ~clk;

    // ---------------- behavioural reference model ----------------
    int          m_busy, m_pc, m_prc, m_stage;
    bit          m_idle, m_ier, m_wake, m_isr, m_pend, m_run, m_pre_en, m_rr;
    bit [2:0]    m_ptv;
    bit [31:0]   m_cnt, m_load;
    bit [15:0]   m_key;

    task automatic m_clear();
        m_pc = 0; m_prc = 0; m_stage = 0;
        m_idle = 0; m_ier = 0; m_wake = 0; m_isr = 0; m_pend = 0; m_run = 0;
        m_pre_en = 0; m_rr = 0; m_ptv = 0; m_cnt = 0; m_load = 0; m_key = 0;
    endtask

    always @(posedge clk) begin
        bit wr, ovf, adv, run_old, pend_old;
        int busy_old;
        bit [31:0] load_old;
        if (!rst_n) begin
            m_clear();
            m_busy = 0;
        end else begin
            busy_old = m_busy; run_old = m_run; pend_old = m_pend; load_old = m_load;
            wr = bus_sel && bus_we && (busy_old == 0);
            ovf = 0; adv = 0;
            if (m_busy > 0) m_busy--;
            if (wr && bus_addr == 8'h10 && bus_wdata[1]) begin
                m_clear();
                m_busy = 4;
            end else begin
                // posted key countdown and apply
                if (pend_old && tick_en) begin
                    if (m_pc == 3) begin
                        m_pend = 0;
                        if (m_stage == 1) begin
                            if (m_key == 16'h4444) m_run = 1;
                            m_stage = 0;
                        end else if (m_stage == 2) begin
                            if (m_key == 16'h5555) m_run = 0;
                            m_stage = 0;
                        end else if (m_key == 16'hBBBB) m_stage = 1;
                        else if (m_key == 16'hAAAA) m_stage = 2;
                    end else m_pc++;
                end
                if (wr && bus_addr == 8'h48 && !pend_old) begin
                    m_pend = 1; m_pc = 0; m_key = bus_wdata[15:0];
                end
                // prescaler and counter
                if (run_old && tick_en) begin
                    if (m_pre_en) begin
                        if (m_prc == (1 << (m_ptv + 1)) - 1) begin m_prc = 0; adv = 1; end
                        else m_prc++;
                    end else adv = 1;
                end
                if (wr && bus_addr == 8'h24) begin
                    m_pre_en = bus_wdata[5]; m_ptv = bus_wdata[4:2]; m_prc = 0;
                end
                if (wr && bus_addr == 8'h28) m_cnt = bus_wdata;
                else if (wr && bus_addr == 8'h30) m_cnt = load_old;
                else if (adv) begin
                    if (m_cnt == 32'hFFFF_FFFF) begin m_cnt = load_old; ovf = 1; end
                    else m_cnt = m_cnt + 1;
                end
                if (wr && bus_addr == 8'h2C) m_load = bus_wdata;
                if (wr && bus_addr == 8'h1C) m_ier = bus_wdata[0];
                if (wr && bus_addr == 8'h20) m_wake = bus_wdata[0];
                if (wr && bus_addr == 8'h10) m_idle = bus_wdata[3];
                if (wr && bus_addr == 8'h18 && bus_wdata[0]) m_isr = 0;
                if (ovf) m_isr = 1;
                m_rr = ovf;
            end
        end
    end

    function automatic bit [31:0] exp_rd(input bit [7:0] a);
        case (a)
            8'h10: return {28'd0, m_idle, 1'b0, (m_busy > 0), 1'b0};
            8'h14: return {31'd0, (m_busy == 0)};
            8'h18: return {31'd0, m_isr};
            8'h1C: return {31'd0, m_ier};
            8'h20: return {31'd0, m_wake};
            8'h24: return {26'd0, m_pre_en, m_ptv, 2'b00};
            8'h28: return m_cnt;
            8'h2C: return m_load;
            8'h34: return {27'd0, m_pend, 4'd0};
            8'h48: return {16'd0, m_key};
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input bit [7:0] a);
        case (a)
            8'h10: return "R9";
            8'h14: return "R9";
            8'h18: return "R3";
            8'h1C: return "R8";
            8'h20: return "R11";
            8'h24: return "R10";
            8'h28: return "R2";
            8'h34: return "R7";
            8'h48: return "R7";
            default: return "R1";
        endcase
    endfunction

    task automatic check(input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %h expected %h at %0t", req, what, got, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(req_of(bus_addr), "model rdata", bus_rdata, exp_rd(bus_addr));
            check("R8", "model irq", {31'd0, irq}, {31'd0, m_isr && m_ier});
            check("R3", "model rst_req", {31'd0, rst_req}, {31'd0, m_rr});
        end
    end

    // Reference tick generator: one pulse every tick_per clocks.
    initial begin
        int n = 0;
        forever begin
            @(posedge clk); #2;
            n++;
            tick_en = (tick_per > 0) && (n % (tick_per > 0 ? tick_per : 1) == 0);
        end
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(posedge clk); #2;
        bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #2;
        bus_sel = 0; bus_we = 0;
    endtask

    task automatic rd(input bit [7:0] a, output bit [31:0] d);
        @(posedge clk); #2;
        bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run hung, got timeout expected finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        bit [31:0] v, v2;
        bit seen;
        idle(4);
        #2 rst_n = 1;
        // R1 reset state
        rd(8'h14, v); check("R1", "status after reset", v, 32'h1);
        rd(8'h28, v); check("R1", "counter after reset", v, 32'h0);
        rd(8'h34, v); check("R1", "pending after reset", v, 32'h0);
        tick_per = 1;
        wr(8'h2C, 32'hFFFF_FC18);
        wr(8'h28, 32'hFFFF_FC18);
        idle(3);
        rd(8'h28, v); check("R1", "counter idle until armed", v, 32'hFFFF_FC18);
        // R4 arm, R7 pending visible
        wr(8'h48, 32'hBBBB);
        rd(8'h34, v); check("R7", "pending after key write", v, 32'h10);
        idle(6);
        rd(8'h34, v); check("R7", "pending cleared", v, 32'h0);
        wr(8'h48, 32'h4444);
        idle(8);
        rd(8'h28, v); idle(2); rd(8'h28, v2);
        check("R4", "counting after arm key", v2 - v, 32'd3);
        // R3 overflow
        wr(8'h28, 32'hFFFF_FFFD);
        seen = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rst_req) seen = 1;
        end
        check("R3", "reset request seen", {31'd0, seen}, 32'd1);
        rd(8'h18, v); check("R3", "overflow flag", v, 32'h1);
        // R8 interrupt enable and clear
        wr(8'h1C, 32'h1);
        @(negedge clk); check("R8", "irq enabled", {31'd0, irq}, 32'd1);
        wr(8'h18, 32'h1);
        @(negedge clk); check("R8", "irq after clear", {31'd0, irq}, 32'd0);
        // R2 trigger reload
        wr(8'h30, 32'h0);
        rd(8'h28, v); check("R2", "trigger reload near load", {31'd0, (v - 32'hFFFF_FC18) < 5}, 32'd1);
        // R5 disarm
        wr(8'h48, 32'hAAAA); idle(6);
        wr(8'h48, 32'h5555); idle(6);
        rd(8'h28, v); idle(4); rd(8'h28, v2);
        check("R5", "stopped counter holds", v2, v);
        // R6 wrong partner and stray word
        wr(8'h48, 32'h1234); idle(6);
        wr(8'h48, 32'hBBBB); idle(6);
        wr(8'h48, 32'h5555); idle(6);
        wr(8'h48, 32'h4444); idle(6);
        rd(8'h28, v); idle(4); rd(8'h28, v2);
        check("R6", "abandoned sequence keeps stopped", v2, v);
        // R7 sparse ticks, write while pending dropped
        tick_per = 3;
        wr(8'h48, 32'hBBBB); idle(16);
        wr(8'h48, 32'h4444);
        wr(8'h48, 32'hAAAA);
        rd(8'h48, v); check("R7", "dropped key write", v, 32'h4444);
        rd(8'h34, v); check("R7", "still pending", v, 32'h10);
        idle(16);
        rd(8'h34, v); check("R7", "pending done", v, 32'h0);
        rd(8'h28, v); idle(8); rd(8'h28, v2);
        check("R4", "running after sparse arm", {31'd0, v2 != v}, 32'd1);
        // R10 prescaler
        tick_per = 1;
        wr(8'h24, 32'h24);
        idle(3);
        rd(8'h28, v); idle(7); rd(8'h28, v2);
        check("R10", "prescale divide by 4", v2 - v, 32'd2);
        wr(8'h24, 32'h0);
        // R11 stored bits
        wr(8'h20, 32'h1); rd(8'h20, v); check("R11", "wake bit", v, 32'h1);
        wr(8'h10, 32'h8); rd(8'h10, v); check("R11", "config bit 3", v, 32'h8);
        rd(8'h28, v); idle(2); rd(8'h28, v2);
        check("R11", "counting unaffected", v2 - v, 32'd3);
        // R9 soft reset
        wr(8'h10, 32'h2);
        rd(8'h14, v); check("R9", "status busy", v, 32'h0);
        rd(8'h10, v); check("R9", "config busy bit", v, 32'h2);
        wr(8'h2C, 32'h5);
        idle(6);
        rd(8'h14, v); check("R9", "status done", v, 32'h1);
        rd(8'h2C, v); check("R9", "load write ignored", v, 32'h0);
        rd(8'h28, v); idle(3); rd(8'h28, v2);
        check("R9", "counter cleared and stopped", v2, 32'h0);
        idle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule